// File: doc/BRIEF.md
# Physical Memory Attribute Checker

This block decides, for each memory request, whether the access may proceed and which attributes govern it. A small table of address regions is loaded through a register port. Each region has a base, an exclusive limit and a 32-bit attribute word made of independent flag bits. A request gives a physical address, the access kind (load, store, instruction fetch or atomic), an atomic opcode and a size. The block picks the lowest-numbered region whose window holds the address and decodes that region's flags. It then returns a permit bit, a fault cause code, a cacheability hint, a flag that says a store must be widened by read-modify-write, and the matching attribute word.

The permission rules go beyond read, write and execute bits. A region must declare itself main memory or IO to be usable, and a reserved flag blocks it even when it keeps its type. On IO regions, atomics are graded as a cumulative class hierarchy, and operand sizes are granted by separate bits. The store-width flags let the memory system find stores that the backing store cannot take directly. The decision is registered, so the answer comes one cycle after the request, and a new request can be accepted every cycle.

Top module: `memattr_checker`

## Requirements
- R1: A region matches when base <= address < limit, compared unsigned. When several regions match, the lowest index wins. An address that matches no region faults with cause 1 and returns an attribute word of zero. Otherwise `rsp_attr` is the winning region's word.
- R2: A config write with `cfg_sel` = 0, 1 or 2 sets the base, the limit or the attribute word of region `cfg_idx`. A lookup in the same cycle as the write sees the old contents, and a lookup in the following cycle sees the new ones. Reset clears every base, limit and attribute word to zero, so no region matches after reset.
- R3: Attribute bits used for type: bit 0 is main memory, bit 1 is IO and bit 2 is reserved. A matched region with neither bit 0 nor bit 1 set faults with cause 1. A region with bit 2 set faults with cause 1 on every access, even when bit 0 or bit 1 is set.
- R4: Access kinds are 0 load, 1 store, 2 fetch and 3 atomic. A load needs bit 3 (read), a store needs bit 4 (write), a fetch needs bit 5 (execute), and an atomic needs both bit 3 and bit 4. A missing permission faults with cause 2.
- R5: Atomic opcodes are 0 swap, 1 and, 2 or, 3 xor, 4 add, 5 min, 6 max, 7 minu and 8 maxu. Swap needs grade 1, opcodes 1 to 3 need grade 2, opcodes 4 to 8 need grade 3, and opcodes 9 to 15 exceed every grade. A region grants the highest grade among bits 23, 24 and 25 (grades 1, 2 and 3). On an IO region, an atomic that needs more than the granted grade faults with cause 3. On a main-memory region the grade is not checked.
- R6: Sizes are given as log2 of the byte count. An atomic of size 2, 3 or 4 needs attribute bit 26, 27 or 28. Any other atomic size, or a clear size bit, faults with cause 4.
- R7: Cause codes are 0 none, 1 illegal or reserved, 2 permission, 3 atomic class and 4 atomic size. When several apply, the lowest non-zero code is reported. `rsp_permit` is 1 exactly when the cause is 0.
- R8: Bits 12 to 18 list the store widths the backing store accepts: 8, 16, 32, 64, 128, 256 and 512 bits (size 0 to 6). A permitted store sets `rsp_rmw` when at least one width bit is set and none of the set widths is at or below the store's size. In every other case `rsp_rmw` is 0.
- R9: `rsp_cacheable` is 1 only for a permitted access whose region has bit 11 (cache read), bit 9 (allocate on read) or bit 10 (allocate on write) set.
- R10: `req_ready` is always 1. A request accepted at one clock edge produces `rsp_valid` = 1 with its result after that edge. When no request is accepted, `rsp_valid` is 0 and the result fields hold their previous values.
- R11: While reset is asserted, `rsp_valid`, `rsp_permit`, `rsp_cacheable` and `rsp_rmw` are 0, `rsp_cause` is 0 and `rsp_attr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the region table |
| cfg_idx | input | 4 | Region index to write |
| cfg_sel | input | 2 | Field select: 0 base, 1 limit, 2 attributes |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_addr | input | 32 | Physical address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 atomic |
| req_amo_op | input | 4 | Atomic opcode |
| req_size | input | 3 | Access size as log2 of bytes |
| rsp_valid | output | 1 | Result valid |
| rsp_permit | output | 1 | Access permitted |
| rsp_cause | output | 3 | Fault cause code |
| rsp_cacheable | output | 1 | Cacheability hint |
| rsp_rmw | output | 1 | Store needs read-modify-write |
| rsp_attr | output | 32 | Attribute word of the winning region |

## Verification
On every cycle, assertions check the response timing and the hold behaviour of the result register. They also check that a permit never carries a cause and that a fault always carries a legal code. Further cycle-level checks: the hint and read-modify-write flags appear only on permitted accesses, a missed lookup always reports the illegal cause, a reserved region always faults, and a table write lands in the addressed entry. The grade arithmetic for atomic classes and the priority among overlapping regions can only be shown by the bench's vectors. The same holds for the ordering of fault causes, the store-width comparison, and the old-versus-new contents when a write meets a lookup in the same cycle.

// File: rtl/memattr_pkg.sv
package memattr_pkg;

  // attribute word flag positions
  localparam int unsigned FLAG_MAIN     = 0;
  localparam int unsigned FLAG_IO       = 1;
  localparam int unsigned FLAG_RSV      = 2;
  localparam int unsigned FLAG_RD       = 3;
  localparam int unsigned FLAG_WR       = 4;
  localparam int unsigned FLAG_EX       = 5;
  localparam int unsigned FLAG_ALLOC_RD = 9;
  localparam int unsigned FLAG_ALLOC_WR = 10;
  localparam int unsigned FLAG_CACHE_RD = 11;
  localparam int unsigned FLAG_WIDTH_LO = 12;
  localparam int unsigned NUM_WIDTHS    = 7;
  localparam int unsigned FLAG_GRADE_LO = 23;
  localparam int unsigned FLAG_ASIZE_LO = 26;
  localparam int unsigned ATTR_W        = 32;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_AMO   = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_ILLEGAL   = 3'd1,
    CAUSE_PERM      = 3'd2,
    CAUSE_AMO_CLASS = 3'd3,
    CAUSE_AMO_SIZE  = 3'd4
  } fault_cause_e;

  // grade an atomic opcode demands; 4 means no region can grant it
  function automatic logic [2:0] grade_needed(input logic [3:0] op);
    logic [2:0] g;
    if (op == 4'd0)       g = 3'd1;
    else if (op <= 4'd3)  g = 3'd2;
    else if (op <= 4'd8)  g = 3'd3;
    else                  g = 3'd4;
    return g;
  endfunction

  // highest grade a region grants from its three cumulative grade bits
  function automatic logic [2:0] grade_granted(input logic [2:0] bits);
    logic [2:0] g;
    if (bits[2])      g = 3'd3;
    else if (bits[1]) g = 3'd2;
    else if (bits[0]) g = 3'd1;
    else              g = 3'd0;
    return g;
  endfunction

endpackage

// File: rtl/memattr_table.sv
module memattr_table #(
  parameter int unsigned NUM_REGIONS = 16,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned CFG_W       = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [IDX_W-1:0]              cfg_idx,
  input  logic [1:0]                    cfg_sel,
  input  logic [CFG_W-1:0]              cfg_wdata,
  output logic [ADDR_W-1:0]             base_o  [NUM_REGIONS],
  output logic [ADDR_W-1:0]             limit_o [NUM_REGIONS],
  output logic [memattr_pkg::ATTR_W-1:0] attr_o [NUM_REGIONS]
);
  import memattr_pkg::*;

  logic [ADDR_W-1:0] base_q  [NUM_REGIONS];
  logic [ADDR_W-1:0] limit_q [NUM_REGIONS];
  logic [ATTR_W-1:0] attr_q  [NUM_REGIONS];

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_entry
    logic hit_idx, en_base, en_limit, en_attr;

    // next-state: per-field clock enables
    always_comb begin
      hit_idx  = cfg_we && (cfg_idx == IDX_W'(i));
      en_base  = hit_idx && (cfg_sel == 2'd0);
      en_limit = hit_idx && (cfg_sel == 2'd1);
      en_attr  = hit_idx && (cfg_sel == 2'd2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        attr_q[i]  <= '0;
      end else begin
        if (en_base)  base_q[i]  <= cfg_wdata[ADDR_W-1:0];
        if (en_limit) limit_q[i] <= cfg_wdata[ADDR_W-1:0];
        if (en_attr)  attr_q[i]  <= cfg_wdata[ATTR_W-1:0];
      end
    end

    assign base_o[i]  = base_q[i];
    assign limit_o[i] = limit_q[i];
    assign attr_o[i]  = attr_q[i];
  end

  // R2: an attribute write lands in the addressed entry
  assert_cfg_attr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd2 && 32'(cfg_idx) < NUM_REGIONS)
      |=> attr_q[$past(cfg_idx)] == $past(cfg_wdata[ATTR_W-1:0]));

  // R2: a base write lands in the addressed entry
  assert_cfg_base_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd0 && 32'(cfg_idx) < NUM_REGIONS)
      |=> base_q[$past(cfg_idx)] == $past(cfg_wdata[ADDR_W-1:0]));

endmodule

// File: rtl/memattr_match.sv
module memattr_match #(
  parameter int unsigned NUM_REGIONS = 16,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned IDX_W       = 4
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [ADDR_W-1:0]              base_i  [NUM_REGIONS],
  input  logic [ADDR_W-1:0]              limit_i [NUM_REGIONS],
  input  logic [memattr_pkg::ATTR_W-1:0] attr_i  [NUM_REGIONS],
  output logic                           hit_any,
  output logic [NUM_REGIONS-1:0]         winner,
  output logic [IDX_W-1:0]               win_idx,
  output logic [memattr_pkg::ATTR_W-1:0] win_attr
);
  import memattr_pkg::*;

  logic [NUM_REGIONS-1:0] in_window;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cmp
    assign in_window[i] = (addr >= base_i[i]) && (addr < limit_i[i]);
  end

  // priority pick: scan from the top so the lowest index is left standing
  always_comb begin
    winner   = '0;
    win_idx  = '0;
    win_attr = '0;
    hit_any  = |in_window;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (in_window[i]) begin
        winner   = '0;
        winner[i] = 1'b1;
        win_idx  = IDX_W'(i);
        win_attr = attr_i[i];
      end
    end
  end

endmodule

// File: rtl/memattr_decide.sv
module memattr_decide (
  input  logic                           hit,
  input  logic [memattr_pkg::ATTR_W-1:0] attr,
  input  memattr_pkg::acc_kind_e         kind,
  input  logic [3:0]                     amo_op,
  input  logic [2:0]                     size,
  output logic                           permit,
  output memattr_pkg::fault_cause_e      cause,
  output logic                           cacheable,
  output logic                           rmw
);
  import memattr_pkg::*;

  logic                  legal, perm_ok, class_ok, size_ok, is_amo;
  logic [2:0]            need_g, have_g;
  logic [NUM_WIDTHS-1:0] widths;
  logic                  width_fits;

  always_comb begin
    is_amo = (kind == KIND_AMO);
    legal  = hit && (attr[FLAG_MAIN] || attr[FLAG_IO]) && !attr[FLAG_RSV];

    unique case (kind)
      KIND_LOAD:  perm_ok = attr[FLAG_RD];
      KIND_STORE: perm_ok = attr[FLAG_WR];
      KIND_FETCH: perm_ok = attr[FLAG_EX];
      default:    perm_ok = attr[FLAG_RD] && attr[FLAG_WR];
    endcase

    need_g   = grade_needed(amo_op);
    have_g   = grade_granted(attr[FLAG_GRADE_LO +: 3]);
    class_ok = attr[FLAG_MAIN] || (need_g <= have_g);

    unique case (size)
      3'd2:    size_ok = attr[FLAG_ASIZE_LO];
      3'd3:    size_ok = attr[FLAG_ASIZE_LO + 1];
      3'd4:    size_ok = attr[FLAG_ASIZE_LO + 2];
      default: size_ok = 1'b0;
    endcase

    if (!legal)                    cause = CAUSE_ILLEGAL;
    else if (!perm_ok)             cause = CAUSE_PERM;
    else if (is_amo && !class_ok)  cause = CAUSE_AMO_CLASS;
    else if (is_amo && !size_ok)   cause = CAUSE_AMO_SIZE;
    else                           cause = CAUSE_NONE;

    permit    = (cause == CAUSE_NONE);
    cacheable = permit &&
                (attr[FLAG_CACHE_RD] || attr[FLAG_ALLOC_RD] || attr[FLAG_ALLOC_WR]);

    // a store fits when some accepted width is at or below its own size
    widths     = attr[FLAG_WIDTH_LO +: NUM_WIDTHS];
    width_fits = 1'b0;
    for (int j = 0; j < NUM_WIDTHS; j++) begin
      if (widths[j] && (j <= int'(size))) width_fits = 1'b1;
    end
    rmw = permit && (kind == KIND_STORE) && (|widths) && !width_fits;
  end

endmodule

// File: rtl/memattr_checker.sv
module memattr_checker #(
  parameter int unsigned NUM_REGIONS = 16,
  parameter int unsigned ADDR_W      = 32,
  localparam int unsigned IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int unsigned CFG_W      = (ADDR_W > 32) ? ADDR_W : 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [3:0]        req_amo_op,
  input  logic [2:0]        req_size,
  output logic              rsp_valid,
  output logic              rsp_permit,
  output logic [2:0]        rsp_cause,
  output logic              rsp_cacheable,
  output logic              rsp_rmw,
  output logic [31:0]       rsp_attr
);
  import memattr_pkg::*;

  logic [ADDR_W-1:0]      tbl_base  [NUM_REGIONS];
  logic [ADDR_W-1:0]      tbl_limit [NUM_REGIONS];
  logic [ATTR_W-1:0]      tbl_attr  [NUM_REGIONS];
  logic                   hit_any;
  logic [NUM_REGIONS-1:0] winner;
  logic [IDX_W-1:0]       win_idx;
  logic [ATTR_W-1:0]      win_attr;
  logic                   d_permit, d_cacheable, d_rmw;
  fault_cause_e           d_cause;

  memattr_table #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CFG_W(CFG_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .base_o(tbl_base), .limit_o(tbl_limit), .attr_o(tbl_attr)
  );

  memattr_match #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_match (
    .addr(req_addr), .base_i(tbl_base), .limit_i(tbl_limit), .attr_i(tbl_attr),
    .hit_any(hit_any), .winner(winner), .win_idx(win_idx), .win_attr(win_attr)
  );

  memattr_decide u_decide (
    .hit(hit_any), .attr(win_attr), .kind(acc_kind_e'(req_kind)),
    .amo_op(req_amo_op), .size(req_size),
    .permit(d_permit), .cause(d_cause), .cacheable(d_cacheable), .rmw(d_rmw)
  );

  assign req_ready = 1'b1;

  // result register: next-state then flops, enabled by an accepted request
  logic              take;
  logic              valid_d, permit_d, cache_d, rmw_d;
  logic [2:0]        cause_d;
  logic [ATTR_W-1:0] attr_d;

  always_comb begin
    take     = req_valid && req_ready;
    valid_d  = take;
    permit_d = take ? d_permit    : rsp_permit;
    cause_d  = take ? d_cause     : rsp_cause;
    cache_d  = take ? d_cacheable : rsp_cacheable;
    rmw_d    = take ? d_rmw       : rsp_rmw;
    attr_d   = take ? win_attr    : rsp_attr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_permit    <= 1'b0;
      rsp_cause     <= CAUSE_NONE;
      rsp_cacheable <= 1'b0;
      rsp_rmw       <= 1'b0;
      rsp_attr      <= '0;
    end else begin
      rsp_valid     <= valid_d;
      rsp_permit    <= permit_d;
      rsp_cause     <= cause_d;
      rsp_cacheable <= cache_d;
      rsp_rmw       <= rmw_d;
      rsp_attr      <= attr_d;
    end
  end

  // R1: at most one region wins a lookup
  assert_single_winner_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winner));

  // R1: a lookup that hits no window reports the illegal cause and no attributes
  assert_miss_illegal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit_any) |=> (rsp_cause == CAUSE_ILLEGAL && rsp_attr == '0));

  // R3: a reserved region always faults as illegal
  assert_reserved_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_any && win_attr[FLAG_RSV])
      |=> (!rsp_permit && rsp_cause == CAUSE_ILLEGAL));

  // R7: a permit carries no cause, a fault carries a defined code
  assert_permit_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_permit |-> rsp_cause == CAUSE_NONE);
  assert_fault_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_permit) |-> (rsp_cause >= 3'd1 && rsp_cause <= 3'd4));

  // R8: the widening flag only on permitted stores
  assert_rmw_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rmw |-> (rsp_permit && $past(req_kind) == KIND_STORE));

  // R9: the cache hint only on permitted accesses
  assert_cache_permit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cacheable |-> rsp_permit);

  // R10: response timing and hold
  assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_cause) && $stable(rsp_attr)));

endmodule

// File: tb/memattr_checker_test.sv
module memattr_checker_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;

  localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2, AM = 2'd3;

  localparam logic [31:0] F_MAIN = 32'h1,       F_IO  = 32'h2,  F_RSV = 32'h4;
  localparam logic [31:0] F_R = 32'h8,          F_W = 32'h10,   F_X = 32'h20;
  localparam logic [31:0] F_WB = 32'h40,        F_AR = 32'h200, F_AW = 32'h400;
  localparam logic [31:0] F_CR = 32'h800;
  localparam logic [31:0] F_W8 = 32'h1000,      F_W32 = 32'h4000, F_W64 = 32'h8000;
  localparam logic [31:0] F_G1 = 32'h0080_0000, F_G2 = 32'h0100_0000, F_G3 = 32'h0200_0000;
  localparam logic [31:0] F_S32 = 32'h0400_0000, F_S64 = 32'h0800_0000, F_S128 = 32'h1000_0000;

  localparam logic [31:0] E0 = F_MAIN | F_R | F_W | F_X | F_CR | F_AR | F_AW | F_WB
                               | F_W64 | F_S32 | F_S64;
  localparam logic [31:0] E1 = F_IO | F_R | F_W | F_G1 | F_G2 | F_S32 | F_W32;
  localparam logic [31:0] E2 = F_MAIN | F_RSV | F_R | F_W | F_X;
  localparam logic [31:0] E3 = F_R | F_W;
  localparam logic [31:0] E4 = F_IO | F_R | F_AW | F_W8;
  localparam logic [31:0] E5 = F_IO | F_R | F_W | F_X | F_G1 | F_G2 | F_G3
                               | F_S32 | F_S64 | F_S128 | F_W8;

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  kind;
    logic [3:0]  op;
    logic [2:0]  size;
    logic        permit;
    logic [2:0]  cause;
    logic        cache;
    logic        rmw;
    logic [31:0] attr;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'h1000, LD, 4'd0, 3'd2, 1'b1, 3'd0, 1'b1, 1'b0, E0},
    '{32'h1FFF, ST, 4'd0, 3'd0, 1'b1, 3'd0, 1'b1, 1'b1, E0},
    '{32'h1800, ST, 4'd0, 3'd3, 1'b1, 3'd0, 1'b1, 1'b0, E0},
    '{32'h2000, ST, 4'd0, 3'd1, 1'b1, 3'd0, 1'b0, 1'b1, E1},
    '{32'h2000, FE, 4'd0, 3'd2, 1'b0, 3'd2, 1'b0, 1'b0, E1},
    '{32'h2004, AM, 4'd1, 3'd2, 1'b1, 3'd0, 1'b0, 1'b0, E1},
    '{32'h2004, AM, 4'd4, 3'd2, 1'b0, 3'd3, 1'b0, 1'b0, E1},
    '{32'h2004, AM, 4'd0, 3'd3, 1'b0, 3'd4, 1'b0, 1'b0, E1},
    '{32'h1004, AM, 4'd8, 3'd3, 1'b1, 3'd0, 1'b1, 1'b0, E0},
    '{32'h1004, AM, 4'd4, 3'd4, 1'b0, 3'd4, 1'b0, 1'b0, E0},
    '{32'h4000, LD, 4'd0, 3'd2, 1'b0, 3'd1, 1'b0, 1'b0, E2},
    '{32'h5000, LD, 4'd0, 3'd2, 1'b0, 3'd1, 1'b0, 1'b0, E3},
    '{32'h6000, ST, 4'd0, 3'd2, 1'b0, 3'd2, 1'b0, 1'b0, E4},
    '{32'h6000, LD, 4'd0, 3'd2, 1'b1, 3'd0, 1'b1, 1'b0, E4},
    '{32'h7000, AM, 4'd7, 3'd4, 1'b1, 3'd0, 1'b0, 1'b0, E5},
    '{32'h7000, AM, 4'd9, 3'd2, 1'b0, 3'd3, 1'b0, 1'b0, E5},
    '{32'h7000, ST, 4'd0, 3'd0, 1'b1, 3'd0, 1'b0, 1'b0, E5},
    '{32'h9000, LD, 4'd0, 3'd2, 1'b0, 3'd1, 1'b0, 1'b0, 32'h0},
    '{32'h0FFF, LD, 4'd0, 3'd2, 1'b0, 3'd1, 1'b0, 1'b0, 32'h0},
    '{32'h6000, AM, 4'd0, 3'd2, 1'b0, 3'd2, 1'b0, 1'b0, E4},
    '{32'h4000, FE, 4'd0, 3'd2, 1'b0, 3'd1, 1'b0, 1'b0, E2}
  };

  logic        clk, rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic [1:0]  req_kind;
  logic [3:0]  req_amo_op;
  logic [2:0]  req_size;
  logic        rsp_valid, rsp_permit, rsp_cacheable, rsp_rmw;
  logic [2:0]  rsp_cause;
  logic [31:0] rsp_attr;

  memattr_checker uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_kind(req_kind), .req_amo_op(req_amo_op), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_permit(rsp_permit), .rsp_cause(rsp_cause),
    .rsp_cacheable(rsp_cacheable), .rsp_rmw(rsp_rmw), .rsp_attr(rsp_attr)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_region(input int idx, input logic [31:0] b,
                            input logic [31:0] l, input logic [31:0] a);
    cfg_write(idx, 2'd0, b);
    cfg_write(idx, 2'd1, l);
    cfg_write(idx, 2'd2, a);
  endtask

  // drive at a falling edge; the result is registered at the next rising edge
  task automatic put_req(input logic [31:0] a, input logic [1:0] k,
                         input logic [3:0] op, input logic [2:0] sz);
    req_valid = 1'b1; req_addr = a; req_kind = k; req_amo_op = op; req_size = sz;
  endtask

  function automatic string cause_tag(input logic [2:0] c);
    case (c)
      3'd1:    return "R3";
      3'd2:    return "R4";
      3'd3:    return "R5";
      3'd4:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_sel = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_kind = '0; req_amo_op = '0; req_size = '0;
    repeat (3) @(negedge clk);

    // R11: outputs in reset
    check("R11", "rsp_valid", 32'(rsp_valid), 0);
    check("R11", "rsp_permit", 32'(rsp_permit), 0);
    check("R11", "rsp_cause", 32'(rsp_cause), 0);
    check("R11", "rsp_attr", rsp_attr, 0);
    check("R10", "req_ready", 32'(req_ready), 1);
    rst_n = 1'b1;

    // R2: empty table after reset, every lookup misses
    @(negedge clk);
    put_req(32'h1000, LD, 4'd0, 3'd2);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", "cause after reset", 32'(rsp_cause), 1);

    set_region(0, 32'h1000, 32'h2000, E0);
    set_region(1, 32'h1800, 32'h3000, E1);
    set_region(2, 32'h4000, 32'h5000, E2);
    set_region(3, 32'h5000, 32'h6000, E3);
    set_region(4, 32'h6000, 32'h7000, E4);
    set_region(5, 32'h7000, 32'h8000, E5);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      put_req(VECS[i].addr, VECS[i].kind, VECS[i].op, VECS[i].size);
      @(negedge clk);
      req_valid = 1'b0;
      check("R10", $sformatf("v%0d valid", i), 32'(rsp_valid), 1);
      check(cause_tag(VECS[i].cause), $sformatf("v%0d cause", i), 32'(rsp_cause),
            32'(VECS[i].cause));
      check("R7", $sformatf("v%0d permit", i), 32'(rsp_permit), 32'(VECS[i].permit));
      check("R9", $sformatf("v%0d cacheable", i), 32'(rsp_cacheable), 32'(VECS[i].cache));
      check("R8", $sformatf("v%0d rmw", i), 32'(rsp_rmw), 32'(VECS[i].rmw));
      check("R1", $sformatf("v%0d attr", i), rsp_attr, VECS[i].attr);
    end

    // R10: idle cycles hold the last result and drop valid
    repeat (3) @(negedge clk);
    check("R10", "valid idle", 32'(rsp_valid), 0);
    check("R10", "cause held", 32'(rsp_cause), 1);
    check("R10", "attr held", rsp_attr, E2);

    // R10: back-to-back requests, one result per cycle
    @(negedge clk);
    put_req(32'h1000, LD, 4'd0, 3'd2);
    @(negedge clk);
    check("R10", "b2b first cause", 32'(rsp_cause), 0);
    put_req(32'h6000, ST, 4'd0, 3'd2);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", "b2b second valid", 32'(rsp_valid), 1);
    check("R10", "b2b second cause", 32'(rsp_cause), 2);

    // R2: a write and a lookup in the same cycle; lookup sees old contents
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd3; cfg_sel = 2'd2; cfg_wdata = F_MAIN | F_R;
    put_req(32'h5000, LD, 4'd0, 3'd2);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R2", "same-cycle old cause", 32'(rsp_cause), 1);
    check("R2", "same-cycle old attr", rsp_attr, E3);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", "next-cycle permit", 32'(rsp_permit), 1);
    check("R2", "next-cycle attr", rsp_attr, F_MAIN | F_R);

    // R11: reset mid-run clears the result and the table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11", "valid in reset", 32'(rsp_valid), 0);
    check("R11", "attr in reset", rsp_attr, 0);
    check("R11", "rmw in reset", 32'(rsp_rmw), 0);
    check("R11", "cacheable in reset", 32'(rsp_cacheable), 0);
    rst_n = 1'b1;
    @(negedge clk);
    put_req(32'h1000, LD, 4'd0, 3'd2);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", "cleared table cause", 32'(rsp_cause), 1);
    check("R1", "cleared table attr", rsp_attr, 0);

    finish_run();
  end

endmodule